// File: doc/BRIEF.md
# Multi-Port Fan PWM Generator

This block produces the pulse-width-modulated drive for a set of fan outputs from one reference clock. Three independent timebases each divide the reference clock through two prescaler stages in series. The first stage divides by a power of two and the second by an even factor. Each timebase then steps a period counter. Every output port selects one timebase and shapes its waveform with two programmable points in that timebase's count: a point where the output rises and a point where it falls.

All settings arrive as plain parallel configuration inputs that may change at any time. A timebase takes its divider and period values only when its counter wraps. A port takes its rise point, fall point and timebase select only when its current timebase wraps. This means a partially updated setting can never produce a malformed period. A port enable and a global count enable act at once.

Top module: `fan_pwm_gen`

## Requirements
- R1: The power-of-two prescaler stage of a timebase divides the reference clock by 2^H, where H is that timebase's 4-bit field in `type_hdiv_i`.
- R2: The even-divide stage that follows divides by 1 when its 4-bit field L in `type_ldiv_i` is 0, and by 2·L otherwise.
- R3: The period counter of a timebase runs from 0 to its 8-bit period value P and then wraps, so every port output on that timebase repeats every 2^H · (L ? 2L : 1) · (P+1) reference clocks.
- R4: When the rise point r is below the fall point f, the output is high for counter values c with r ≤ c < f. The output is registered, so it reflects the counter value of the previous clock.
- R5: When r is above f, the output is high for c ≥ r or c < f. With f = 0 this means high from r to the end of the period.
- R6: When r = f = 0, the output stays high for the whole period. When r = f ≠ 0, the output stays low.
- R7: The 2-bit port select chooses timebase 0, 1 or 2 by value. The value 3 is reserved, and a port on it drives low.
- R8: A port whose enable is low drives low from the next clock onward. This enable is not held back until a wrap.
- R9: While `clk_en_i` is low, every prescaler and period counter holds its value.
- R10: A timebase loads H, L and P at its wrap. A port loads its rise, fall and select at the wrap of the timebase it currently uses, or on every clock while its active select is reserved.
- R11: Asynchronous reset clears all counters and loaded settings and drives every output low. After reset, each timebase wraps on its first enabled clock and loads its inputs there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Global count enable for all timebases |
| type_hdiv_i | input | NUM_TYPES*4 | Power-of-two exponent H per timebase |
| type_ldiv_i | input | NUM_TYPES*4 | Even-divide field L per timebase |
| type_period_i | input | NUM_TYPES*8 | Period value P per timebase |
| port_en_i | input | NUM_PORTS | Per-port output enable |
| port_sel_i | input | NUM_PORTS*2 | Per-port timebase select (3 reserved) |
| port_rise_i | input | NUM_PORTS*8 | Per-port rise point |
| port_fall_i | input | NUM_PORTS*8 | Per-port fall point |
| pwm_o | output | NUM_PORTS | Fan PWM outputs |

## Verification
On every cycle, the embedded assertions check four properties. The period counter never passes its loaded period. Counters freeze while the count enable is low. Newly loaded settings match the inputs present at the wrap. A disabled port or a port on the reserved select is low on the following clock. The waveform itself can only be shown by the bench's scenarios, which compare each output on every cycle against a reference model. That waveform includes the rise and fall ordering cases, full duty, and the deferral of mid-period changes to the wrap. The bench also measures the output repetition interval against 2^H·(L?2L:1)·(P+1).

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int unsigned DEF_PORTS  = 8;
  localparam int unsigned DEF_TYPES  = 3;
  localparam int unsigned DEF_HDIV_W = 4;
  localparam int unsigned DEF_LDIV_W = 4;
  localparam int unsigned DEF_PT_W   = 8;

  typedef struct packed {
    logic [DEF_HDIV_W-1:0] hdiv;
    logic [DEF_LDIV_W-1:0] ldiv;
    logic [DEF_PT_W-1:0]   period;
  } tbase_cfg_t;
endpackage

// File: rtl/fan_pwm_prescaler.sv
module fan_pwm_prescaler #(
  parameter int unsigned HDIV_W = fan_pwm_pkg::DEF_HDIV_W,
  parameter int unsigned LDIV_W = fan_pwm_pkg::DEF_LDIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HDIV_W-1:0] hdiv_i,
  input  logic [LDIV_W-1:0] ldiv_i,
  output logic              tick_o
);
  localparam int unsigned HCNT_W = (1 << HDIV_W) - 1;
  localparam int unsigned LCNT_W = LDIV_W + 1;

  logic [HCNT_W-1:0] hcnt_q, hmax;
  logic [LCNT_W-1:0] lcnt_q, lmax;
  logic              h_tick;

  always_comb begin
    hmax   = ~({HCNT_W{1'b1}} << hdiv_i);
    lmax   = (ldiv_i == '0) ? '0 : ({ldiv_i, 1'b0} - LCNT_W'(1));
    h_tick = en_i && (hcnt_q == hmax);
    tick_o = h_tick && (lcnt_q == lmax);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      lcnt_q <= '0;
    end else if (en_i) begin
      hcnt_q <= h_tick ? '0 : hcnt_q + HCNT_W'(1);
      if (h_tick) lcnt_q <= tick_o ? '0 : lcnt_q + LCNT_W'(1);
    end
  end

  assert_hold_hcnt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(hcnt_q) && $stable(lcnt_q));
  assert_stage_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= hmax);
endmodule

// File: rtl/fan_pwm_timebase.sv
module fan_pwm_timebase #(
  parameter int unsigned HDIV_W = fan_pwm_pkg::DEF_HDIV_W,
  parameter int unsigned LDIV_W = fan_pwm_pkg::DEF_LDIV_W,
  parameter int unsigned PT_W   = fan_pwm_pkg::DEF_PT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HDIV_W-1:0] hdiv_i,
  input  logic [LDIV_W-1:0] ldiv_i,
  input  logic [PT_W-1:0]   period_i,
  output logic [PT_W-1:0]   cnt_o,
  output logic              wrap_o
);
  logic [HDIV_W-1:0] hdiv_q;
  logic [LDIV_W-1:0] ldiv_q;
  logic [PT_W-1:0]   per_q, cnt_q;
  logic              tick;

  fan_pwm_prescaler #(.HDIV_W(HDIV_W), .LDIV_W(LDIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .hdiv_i (hdiv_q),
    .ldiv_i (ldiv_q),
    .tick_o (tick)
  );

  assign wrap_o = tick && (cnt_q == per_q);
  assign cnt_o  = cnt_q;

  // settings only move at the wrap, where both prescaler stages sit at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hdiv_q <= '0;
      ldiv_q <= '0;
      per_q  <= '0;
    end else if (wrap_o) begin
      cnt_q  <= '0;
      hdiv_q <= hdiv_i;
      ldiv_q <= ldiv_i;
      per_q  <= period_i;
    end else if (tick) begin
      cnt_q  <= cnt_q + PT_W'(1);
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_q);
  assert_cnt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  assert_cfg_at_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (per_q == $past(period_i)) && (hdiv_q == $past(hdiv_i)));
  assert_cfg_steady_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> $stable(per_q) && $stable(ldiv_q));
endmodule

// File: rtl/fan_pwm_port.sv
module fan_pwm_port #(
  parameter int unsigned NUM_TYPES = fan_pwm_pkg::DEF_TYPES,
  parameter int unsigned PT_W      = fan_pwm_pkg::DEF_PT_W,
  parameter int unsigned SEL_W     = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [PT_W-1:0]           rise_i,
  input  logic [PT_W-1:0]           fall_i,
  input  logic [NUM_TYPES*PT_W-1:0] cnt_i,
  input  logic [NUM_TYPES-1:0]      wrap_i,
  output logic                      pwm_o
);
  logic [SEL_W-1:0] sel_q;
  logic [PT_W-1:0]  rise_q, fall_q, cnt;
  logic             sel_ok, load, lvl, pwm_q;

  always_comb begin
    cnt    = '0;
    load   = 1'b1;
    sel_ok = 1'b0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      if (sel_q == SEL_W'(t)) begin
        cnt    = cnt_i[t*PT_W +: PT_W];
        load   = wrap_i[t];
        sel_ok = 1'b1;
      end
    end
  end

  always_comb begin
    if (rise_q == fall_q)     lvl = (rise_q == '0);
    else if (rise_q < fall_q) lvl = (cnt >= rise_q) && (cnt < fall_q);
    else                      lvl = (cnt >= rise_q) || (cnt < fall_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      if (load) begin
        sel_q  <= sel_i;
        rise_q <= rise_i;
        fall_q <= fall_i;
      end
      pwm_q <= en_i && sel_ok && lvl;
    end
  end

  assign pwm_o = pwm_q;

  assert_off_when_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);
  assert_rsv_sel_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ok |=> !pwm_o);
  assert_rsv_sel_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ok |=> (sel_q == $past(sel_i)) && (rise_q == $past(rise_i)));
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int unsigned NUM_PORTS = fan_pwm_pkg::DEF_PORTS,
  parameter int unsigned NUM_TYPES = fan_pwm_pkg::DEF_TYPES,
  parameter int unsigned HDIV_W    = fan_pwm_pkg::DEF_HDIV_W,
  parameter int unsigned LDIV_W    = fan_pwm_pkg::DEF_LDIV_W,
  parameter int unsigned PT_W      = fan_pwm_pkg::DEF_PT_W,
  localparam int unsigned SEL_W    = $clog2(NUM_TYPES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clk_en_i,
  input  logic [NUM_TYPES*HDIV_W-1:0] type_hdiv_i,
  input  logic [NUM_TYPES*LDIV_W-1:0] type_ldiv_i,
  input  logic [NUM_TYPES*PT_W-1:0]   type_period_i,
  input  logic [NUM_PORTS-1:0]        port_en_i,
  input  logic [NUM_PORTS*SEL_W-1:0]  port_sel_i,
  input  logic [NUM_PORTS*PT_W-1:0]   port_rise_i,
  input  logic [NUM_PORTS*PT_W-1:0]   port_fall_i,
  output logic [NUM_PORTS-1:0]        pwm_o
);
  logic [NUM_TYPES*PT_W-1:0] cnt_all;
  logic [NUM_TYPES-1:0]      wrap_all;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_tbase
    fan_pwm_timebase #(.HDIV_W(HDIV_W), .LDIV_W(LDIV_W), .PT_W(PT_W)) u_tb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (clk_en_i),
      .hdiv_i   (type_hdiv_i[t*HDIV_W +: HDIV_W]),
      .ldiv_i   (type_ldiv_i[t*LDIV_W +: LDIV_W]),
      .period_i (type_period_i[t*PT_W +: PT_W]),
      .cnt_o    (cnt_all[t*PT_W +: PT_W]),
      .wrap_o   (wrap_all[t])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    fan_pwm_port #(.NUM_TYPES(NUM_TYPES), .PT_W(PT_W), .SEL_W(SEL_W)) u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (port_en_i[p]),
      .sel_i  (port_sel_i[p*SEL_W +: SEL_W]),
      .rise_i (port_rise_i[p*PT_W +: PT_W]),
      .fall_i (port_fall_i[p*PT_W +: PT_W]),
      .cnt_i  (cnt_all),
      .wrap_i (wrap_all),
      .pwm_o  (pwm_o[p])
    );
  end
endmodule

// File: tb/fan_pwm_gen_tb_top.sv
module fan_pwm_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic [11:0]   hdiv = '0, ldiv = '0;
  logic [23:0]   per = '0;
  logic [NP-1:0] en = '0;
  logic [15:0]   sel = '0;
  logic [63:0]   rise = '0, fall = '0;
  logic [NP-1:0] pwm;

  int vectors = 0, fails = 0, cyc = 0;
  int m_pc[NT], m_cnt[NT], m_h[NT], m_l[NT], m_p[NT];
  int m_sel[NP], m_rise[NP], m_fall[NP];
  logic [NP-1:0] m_pwm;
  logic prev0 = 1'b0;
  int last_rise = -1, gap = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_pwm_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en),
    .type_hdiv_i(hdiv), .type_ldiv_i(ldiv), .type_period_i(per),
    .port_en_i(en), .port_sel_i(sel), .port_rise_i(rise), .port_fall_i(fall),
    .pwm_o(pwm)
  );

  function automatic int div_h(int h); return 1 << h; endfunction
  function automatic int div_l(int l); return (l == 0) ? 1 : 2 * l; endfunction
  function automatic bit level(int c, int r, int f);
    if (r == f) return (r == 0);
    if (r < f)  return (c >= r) && (c < f);
    return (c >= r) || (c < f);
  endfunction

  task automatic model_step();
    bit tk[NT];
    bit wr[NT];
    logic [NP-1:0] np;
    for (int t = 0; t < NT; t++) begin
      tk[t] = clk_en && (m_pc[t] == div_h(m_h[t]) * div_l(m_l[t]) - 1);
      wr[t] = tk[t] && (m_cnt[t] == m_p[t]);
    end
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        m_pc[t] = 0; m_cnt[t] = 0; m_h[t] = 0; m_l[t] = 0; m_p[t] = 0;
      end
      for (int p = 0; p < NP; p++) begin
        m_sel[p] = 0; m_rise[p] = 0; m_fall[p] = 0;
      end
      m_pwm = '0;
      return;
    end
    for (int p = 0; p < NP; p++) begin
      int s = m_sel[p];
      bit ld;
      np[p] = (s < NT) ? (en[p] && level(m_cnt[s], m_rise[p], m_fall[p])) : 1'b0;
      ld = (s >= NT) ? 1'b1 : wr[s];
      if (ld) begin
        m_sel[p]  = int'(sel[p*2 +: 2]);
        m_rise[p] = int'(rise[p*8 +: 8]);
        m_fall[p] = int'(fall[p*8 +: 8]);
      end
    end
    m_pwm = np;
    for (int t = 0; t < NT; t++) begin
      if (tk[t]) begin
        m_pc[t] = 0;
        if (wr[t]) begin
          m_cnt[t] = 0;
          m_h[t] = int'(hdiv[t*4 +: 4]);
          m_l[t] = int'(ldiv[t*4 +: 4]);
          m_p[t] = int'(per[t*8 +: 8]);
        end else m_cnt[t] = m_cnt[t] + 1;
      end else if (clk_en) m_pc[t] = m_pc[t] + 1;
    end
  endtask

  task automatic check_bit(string tag, int p, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s port %0d cycle %0d: pwm actual %b expected %b", tag, p, cyc, act, exp);
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      cyc++;
      for (int p = 0; p < NP; p++) check_bit(tag, p, pwm[p], m_pwm[p]);
      if (pwm[0] && !prev0) begin
        if (last_rise >= 0) gap = cyc - last_rise;
        last_rise = cyc;
      end
      prev0 = pwm[0];
    end
  endtask

  task automatic set_type(int t, int h, int l, int p);
    hdiv[t*4 +: 4] = 4'(h); ldiv[t*4 +: 4] = 4'(l); per[t*8 +: 8] = 8'(p);
  endtask

  task automatic set_port(int p, bit e, int s, int r, int f);
    en[p] = e; sel[p*2 +: 2] = 2'(s); rise[p*8 +: 8] = 8'(r); fall[p*8 +: 8] = 8'(f);
  endtask

  task automatic check_gap(int exp, string tag);
    vectors++;
    if (gap != exp) begin
      fails++;
      $display("FAIL %s: repeat interval actual %0d expected %0d", tag, gap, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [NP-1:0] held;
    void'($urandom(32'd4242));
    @(negedge clk);
    run(3, "R11 reset state");
    for (int p = 0; p < NP; p++) check_bit("R11 outputs low in reset", p, pwm[p], 1'b0);
    rst_n = 1'b1;
    clk_en = 1'b1;

    set_type(0, 0, 0, 9);
    set_type(1, 1, 0, 7);
    set_type(2, 0, 2, 5);
    set_port(0, 1, 0, 2, 6);  // R4
    set_port(1, 1, 0, 7, 3);  // R5
    set_port(2, 1, 1, 0, 0);  // R6 full duty
    set_port(3, 1, 1, 4, 4);  // R6 equal nonzero -> low
    set_port(4, 1, 2, 3, 0);  // R5 fall zero
    set_port(5, 1, 3, 1, 5);  // R7 reserved
    set_port(6, 0, 0, 0, 5);  // R8 disabled
    set_port(7, 1, 2, 1, 4);  // R7 type select 2
    run(300, "R4 R5 R6 R7 R8 directed mix");

    set_port(2, 0, 1, 0, 0);
    run(1, "R8 enable acts next clock");
    check_bit("R8 disabled full-duty port", 2, pwm[2], 1'b0);
    set_port(2, 1, 1, 0, 0);

    // mid-period changes deferred to wrap
    run(4, "R10 pre-change");
    set_port(0, 1, 0, 5, 8);
    set_type(0, 1, 1, 12);
    set_port(4, 1, 1, 2, 5);
    run(250, "R10 latched at wrap");

    // counters hold with clock enable low
    clk_en = 1'b0;
    run(1, "R9 enable drop");
    held = pwm;
    run(40, "R9 counters hold");
    for (int p = 0; p < NP; p++) check_bit("R9 outputs frozen", p, pwm[p], held[p]);
    clk_en = 1'b1;
    run(60, "R9 resume");

    // repetition interval measurement, port 0 on timebase 0
    set_type(0, 2, 3, 4);
    set_port(0, 1, 0, 0, 2);
    run(300, "R1 R2 R3 settle");
    last_rise = -1; gap = -1;
    run(300, "R1 R2 R3 interval");
    check_gap(4 * 6 * 5, "R1 R2 R3 H=2 L=3 P=4");
    set_type(0, 1, 0, 7);
    run(300, "R1 R2 settle");
    last_rise = -1; gap = -1;
    run(100, "R1 R2 interval");
    check_gap(2 * 1 * 8, "R1 R2 H=1 L=0 P=7");
    set_type(0, 0, 1, 2);
    run(100, "R2 settle");
    last_rise = -1; gap = -1;
    run(60, "R2 interval");
    check_gap(1 * 2 * 3, "R2 H=0 L=1 P=2");

    // constrained random rounds
    for (int k = 0; k < 20; k++) begin
      for (int t = 0; t < NT; t++)
        set_type(t, $urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 15));
      for (int p = 0; p < NP; p++)
        set_port(p, ($urandom_range(0, 7) != 0), $urandom_range(0, 3),
                 $urandom_range(0, 17), $urandom_range(0, 17));
      if ((k % 4) == 3) begin
        for (int p = 0; p < NP; p++) set_port(p, 1'b1, p % 3, 0, 0);
      end
      for (int j = 0; j < 6; j++) begin
        clk_en = ($urandom_range(0, 5) != 0);
        run(60, "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end
      clk_en = 1'b1;
    end

    // reset mid-run
    rst_n = 1'b0;
    run(2, "R11 reset reasserted");
    for (int p = 0; p < NP; p++) check_bit("R11 outputs cleared", p, pwm[p], 1'b0);
    rst_n = 1'b1;
    run(200, "R11 restart");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule